// File: doc/BRIEF.md
# Physical Memory Attribute Region Checker

This block classifies a physical address against two sets of address windows that are fixed when the chip is built. One set marks the windows from which code may be fetched. The other set marks the windows where reads or writes have side effects, so that repeating an access is unsafe. A front end or a load/store path gives it the physical address of a request and says whether the request is an instruction fetch or a data access. The block answers with two match flags and an exception record.

Each window is naturally aligned and has a power-of-two size. The window's size is turned into a bit mask that keeps the upper address bits. An address falls in a window when its masked bits equal the masked base. If a fetch lands outside every executable window, the block raises an instruction access fault. This fault replaces any exception the request already carried, and it reports the faulting address.

The result can be taken from the same cycle, or from a one-cycle output register chosen by a parameter. If a rule count is above 16, or a window size is not a power of two, elaboration stops with an error.

Top module: `pma_checker`

## Requirements
- R1: An address is inside a window when (address AND mask) equals (base AND mask), where mask is all ones shifted left by log2 of the window size. `exec_hit_o` is 1 when the address is inside any executable window. The default executable windows are 0x0 (size 0x1000), 0x1_0000 (size 0x1_0000) and 0x8000_0000 (size 0x4000_0000).
- R2: When no executable window is configured, `exec_hit_o` is always 1 and no access fault is ever raised.
- R3: A valid fetch (`req_fetch_i`=1) that hits no executable window gives `exc_valid_o`=1, `exc_cause_o`=1 (instruction access fault) and `exc_value_o` equal to the fetch address.
- R4: The access fault of R3 replaces any incoming exception (`prior_exc_valid_i`=1) on the same request, whatever its cause and value.
- R5: A valid fetch that hits an executable window passes the incoming exception through unchanged (valid, cause, value). With no incoming exception, `exc_valid_o` is 0.
- R6: A valid data access (`req_fetch_i`=0) never raises an access fault. The incoming exception passes through unchanged, and `exec_hit_o` is still reported.
- R7: `nonidem_o` is 1 only for a valid data access inside any side-effect window. It is 0 for fetches, and always 0 when no side-effect window is configured. The default side-effect windows are 0x1000_0000 (size 0x1000) and 0x2000_0000 (size 0x100_0000).
- R8: With `REG_OUT`=1, every output shows the request of the previous cycle, and `valid_o` is `req_valid_i` delayed by one cycle. With `REG_OUT`=0, the outputs follow the inputs in the same cycle. When the request is not valid, `valid_o` and `exc_valid_o` are 0.
- R9: While `rst_ni` is low, `valid_o` and `exc_valid_o` of the registered stage are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | A request is present |
| req_fetch_i | input | 1 | 1 = instruction fetch, 0 = data load/store |
| paddr_i | input | 64 | Physical address of the request |
| prior_exc_valid_i | input | 1 | Request already carries an exception |
| prior_exc_cause_i | input | 64 | Cause of the incoming exception |
| prior_exc_value_i | input | 64 | Value of the incoming exception |
| valid_o | output | 1 | Result is valid |
| exec_hit_o | output | 1 | Address lies in an executable window |
| nonidem_o | output | 1 | Data access lies in a side-effect window |
| exc_valid_o | output | 1 | Exception record is valid |
| exc_cause_o | output | 64 | Exception cause |
| exc_value_o | output | 64 | Exception value |

## Verification
The bench fetches from the first and last byte of each executable window and from the bytes just outside them. A design that derived the mask one bit short or one bit long would pass or fault the wrong edge byte. It sends fetch misses that carry a page-fault-like exception, and a design with the wrong priority would let the old cause escape. It also sends data accesses to non-executable and side-effect addresses: a design that did not look at the access type would fault on data, or would flag side effects on fetches. A second instance with no windows and no register checks that an empty rule set allows every fetch and that the same-cycle path works.

// File: rtl/pma_pkg.sv
package pma_pkg;

  localparam int unsigned PA_W      = 64;
  localparam int unsigned CAUSE_W   = 64;
  localparam int unsigned MAX_RULES = 16;

  localparam logic [CAUSE_W-1:0] CAUSE_INSTR_ACCESS = CAUSE_W'(1);

  typedef logic [PA_W-1:0]                 pa_t;
  typedef logic [MAX_RULES-1:0][PA_W-1:0]  rule_tbl_t;

  typedef struct packed {
    logic               valid;
    logic               exec_hit;
    logic               nonidem;
    logic               exc_valid;
    logic [CAUSE_W-1:0] cause;
    pa_t                value;
  } pma_result_t;

  // Keep only the bits above the window offset
  function automatic pa_t size_to_mask(input pa_t size);
    return {PA_W{1'b1}} << $clog2(size);
  endfunction

  function automatic bit is_pow2(input pa_t size);
    return (size != '0) && ((size & (size - pa_t'(1))) == '0);
  endfunction

endpackage

// File: rtl/pma_region_match.sv
module pma_region_match
  import pma_pkg::*;
#(
  parameter int unsigned N_RULES   = 1,
  parameter rule_tbl_t   BASES     = '0,
  parameter rule_tbl_t   SIZES     = {MAX_RULES{pa_t'(1)}},
  parameter bit          EMPTY_HIT = 1'b0
) (
  input  pa_t  paddr_i,
  output logic any_hit_o
);

  logic [MAX_RULES-1:0] rule_hit;

  if (N_RULES > MAX_RULES) begin : g_count_err
    $error("pma_region_match: rule count above limit");
  end

  for (genvar i = 0; i < MAX_RULES; i++) begin : g_rule
    if (i < N_RULES) begin : g_used
      if (!is_pow2(SIZES[i])) begin : g_size_err
        $error("pma_region_match: window size must be a power of two");
      end
      localparam pa_t MASK = size_to_mask(SIZES[i]);
      localparam pa_t BASE_M = BASES[i] & MASK;
      assign rule_hit[i] = ((paddr_i & MASK) == BASE_M);
    end else begin : g_unused
      assign rule_hit[i] = 1'b0;
    end
  end

  if (N_RULES == 0) begin : g_empty
    assign any_hit_o = EMPTY_HIT;
  end else begin : g_rules
    assign any_hit_o = |rule_hit;
  end

endmodule

// File: rtl/pma_fault_merge.sv
module pma_fault_merge
  import pma_pkg::*;
(
  input  logic               req_valid_i,
  input  logic               req_fetch_i,
  input  pa_t                paddr_i,
  input  logic               exec_hit_i,
  input  logic               nonidem_hit_i,
  input  logic               prior_valid_i,
  input  logic [CAUSE_W-1:0] prior_cause_i,
  input  pa_t                prior_value_i,
  output pma_result_t        res_o
);

  logic fetch_fault;

  assign fetch_fault = req_valid_i & req_fetch_i & ~exec_hit_i;

  always_comb begin
    res_o.valid    = req_valid_i;
    res_o.exec_hit = exec_hit_i;
    res_o.nonidem  = req_valid_i & ~req_fetch_i & nonidem_hit_i;
    // Access fault wins over whatever the request already carries
    if (fetch_fault) begin
      res_o.exc_valid = 1'b1;
      res_o.cause     = CAUSE_INSTR_ACCESS;
      res_o.value     = paddr_i;
    end else begin
      res_o.exc_valid = req_valid_i & prior_valid_i;
      res_o.cause     = prior_cause_i;
      res_o.value     = prior_value_i;
    end
  end

endmodule

// File: rtl/pma_out_stage.sv
module pma_out_stage
  import pma_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  pma_result_t res_i,
  output pma_result_t res_o
);

  if (REG_OUT) begin : g_reg
    logic        valid_q, valid_d;
    logic        exc_q, exc_d;
    logic        load_en;
    pma_result_t data_q, data_d;

    assign load_en = res_i.valid;

    always_comb begin
      valid_d = res_i.valid;
      exc_d   = res_i.valid & res_i.exc_valid;
      data_d  = data_q;
      if (load_en) data_d = res_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        exc_q   <= 1'b0;
      end else begin
        valid_q <= valid_d;
        exc_q   <= exc_d;
      end
    end

    always_ff @(posedge clk_i) begin
      data_q <= data_d;
    end

    always_comb begin
      res_o           = data_q;
      res_o.valid     = valid_q;
      res_o.exc_valid = exc_q;
    end

    assert_valid_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      res_i.valid |=> res_o.valid);
    assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !res_i.valid |=> (!res_o.valid && !res_o.exc_valid));
    assert_value_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      res_i.valid |=> (res_o.value == $past(res_i.value)));
  end else begin : g_comb
    assign res_o = res_i;
  end

endmodule

// File: rtl/pma_checker.sv
module pma_checker
  import pma_pkg::*;
#(
  parameter int unsigned N_EXEC    = 3,
  parameter rule_tbl_t   EXEC_BASE = {{13{pa_t'(0)}}, pa_t'(64'h8000_0000),
                                      pa_t'(64'h1_0000), pa_t'(64'h0)},
  parameter rule_tbl_t   EXEC_SIZE = {{13{pa_t'(1)}}, pa_t'(64'h4000_0000),
                                      pa_t'(64'h1_0000), pa_t'(64'h1000)},
  parameter int unsigned N_NONIDEM = 2,
  parameter rule_tbl_t   NI_BASE   = {{14{pa_t'(0)}}, pa_t'(64'h2000_0000),
                                      pa_t'(64'h1000_0000)},
  parameter rule_tbl_t   NI_SIZE   = {{14{pa_t'(1)}}, pa_t'(64'h100_0000),
                                      pa_t'(64'h1000)},
  parameter bit          REG_OUT   = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_fetch_i,
  input  logic [PA_W-1:0]    paddr_i,
  input  logic               prior_exc_valid_i,
  input  logic [CAUSE_W-1:0] prior_exc_cause_i,
  input  logic [PA_W-1:0]    prior_exc_value_i,
  output logic               valid_o,
  output logic               exec_hit_o,
  output logic               nonidem_o,
  output logic               exc_valid_o,
  output logic [CAUSE_W-1:0] exc_cause_o,
  output logic [PA_W-1:0]    exc_value_o
);

  logic        exec_hit_c;
  logic        ni_hit_c;
  pma_result_t res_c;
  pma_result_t res_q;

  pma_region_match #(
    .N_RULES(N_EXEC), .BASES(EXEC_BASE), .SIZES(EXEC_SIZE), .EMPTY_HIT(1'b1)
  ) u_exec_match (
    .paddr_i  (paddr_i),
    .any_hit_o(exec_hit_c)
  );

  pma_region_match #(
    .N_RULES(N_NONIDEM), .BASES(NI_BASE), .SIZES(NI_SIZE), .EMPTY_HIT(1'b0)
  ) u_ni_match (
    .paddr_i  (paddr_i),
    .any_hit_o(ni_hit_c)
  );

  pma_fault_merge u_merge (
    .req_valid_i  (req_valid_i),
    .req_fetch_i  (req_fetch_i),
    .paddr_i      (paddr_i),
    .exec_hit_i   (exec_hit_c),
    .nonidem_hit_i(ni_hit_c),
    .prior_valid_i(prior_exc_valid_i),
    .prior_cause_i(prior_exc_cause_i),
    .prior_value_i(prior_exc_value_i),
    .res_o        (res_c)
  );

  pma_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .res_i (res_c),
    .res_o (res_q)
  );

  assign valid_o     = res_q.valid;
  assign exec_hit_o  = res_q.exec_hit;
  assign nonidem_o   = res_q.nonidem;
  assign exc_valid_o = res_q.exc_valid;
  assign exc_cause_o = res_q.cause;
  assign exc_value_o = res_q.value;

  assert_fault_record_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_fetch_i && !exec_hit_c) |->
      (res_c.exc_valid && res_c.cause == CAUSE_INSTR_ACCESS && res_c.value == paddr_i));
  assert_hit_no_fault_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_fetch_i && exec_hit_c && !prior_exc_valid_i) |-> !res_c.exc_valid);
  assert_data_no_fault_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_fetch_i && !prior_exc_valid_i) |-> !res_c.exc_valid);
  assert_fetch_not_nonidem_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_fetch_i) |-> !res_c.nonidem);

  if (N_EXEC == 0) begin : g_open_chk
    assert_empty_exec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i |-> (exec_hit_c && (res_c.exc_valid == prior_exc_valid_i)));
  end

  if (REG_OUT) begin : g_rst_chk
    assert_reset_clear_R9: assert property (@(posedge clk_i)
      !rst_ni |-> (!valid_o && !exc_valid_o));
  end

endmodule

// File: tb/tb_pma_checker.sv
module tb_pma_checker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rv = 1'b0, rf = 1'b0, pv = 1'b0;
  logic [63:0] pa = '0, pc = '0, pval = '0;

  logic        v_a, eh_a, ni_a, ev_a;
  logic [63:0] ec_a, ex_a;
  logic        v_b, eh_b, ni_b, ev_b;
  logic [63:0] ec_b, ex_b;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pma_checker dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(rv), .req_fetch_i(rf), .paddr_i(pa),
    .prior_exc_valid_i(pv), .prior_exc_cause_i(pc), .prior_exc_value_i(pval),
    .valid_o(v_a), .exec_hit_o(eh_a), .nonidem_o(ni_a), .exc_valid_o(ev_a),
    .exc_cause_o(ec_a), .exc_value_o(ex_a));

  pma_checker #(.N_EXEC(0), .N_NONIDEM(0), .REG_OUT(1'b0)) dut_open (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(rv), .req_fetch_i(rf), .paddr_i(pa),
    .prior_exc_valid_i(pv), .prior_exc_cause_i(pc), .prior_exc_value_i(pval),
    .valid_o(v_b), .exec_hit_o(eh_b), .nonidem_o(ni_b), .exc_valid_o(ev_b),
    .exc_cause_o(ec_b), .exc_value_o(ex_b));

  function automatic bit in_win(input logic [63:0] a, input logic [63:0] b,
                                input logic [63:0] sz);
    logic [63:0] keep;
    keep = ~(sz - 64'd1);
    return (a & keep) == (b & keep);
  endfunction

  function automatic bit exp_exec(input logic [63:0] a);
    return in_win(a, 64'h0, 64'h1000) || in_win(a, 64'h1_0000, 64'h1_0000) ||
           in_win(a, 64'h8000_0000, 64'h4000_0000);
  endfunction

  function automatic bit exp_ni(input logic [63:0] a);
    return in_win(a, 64'h1000_0000, 64'h1000) || in_win(a, 64'h2000_0000, 64'h100_0000);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Drive at negedge, check both instances just after the next posedge
  task automatic op(input logic v, input logic f, input logic [63:0] a,
                    input logic p_v, input logic [63:0] p_c, input logic [63:0] p_val);
    bit          hit, fault;
    @(negedge clk);
    rv = v; rf = f; pa = a; pv = p_v; pc = p_c; pval = p_val;
    @(posedge clk);
    #1;
    hit   = exp_exec(a);
    fault = v && f && !hit;
    chk("R8", "valid_o", 64'(v_a), 64'(v));
    if (v) begin
      chk("R1", "exec_hit_o", 64'(eh_a), 64'(hit));
      chk("R7", "nonidem_o", 64'(ni_a), 64'(!f && exp_ni(a)));
      if (fault) begin
        chk("R3", "exc_valid_o", 64'(ev_a), 64'd1);
        chk("R3", "exc_cause_o", ec_a, 64'd1);
        chk(p_v ? "R4" : "R3", "exc_value_o", ex_a, a);
      end else begin
        chk(f ? "R5" : "R6", "exc_valid_o", 64'(ev_a), 64'(p_v));
        if (p_v) begin
          chk(f ? "R5" : "R6", "exc_cause_o", ec_a, p_c);
          chk(f ? "R5" : "R6", "exc_value_o", ex_a, p_val);
        end
      end
      chk("R2", "open exec_hit_o", 64'(eh_b), 64'd1);
      chk("R2", "open exc_valid_o", 64'(ev_b), 64'(p_v));
      chk("R7", "open nonidem_o", 64'(ni_b), 64'd0);
      chk("R8", "open valid_o", 64'(v_b), 64'd1);
    end else begin
      chk("R8", "idle exc_valid_o", 64'(ev_a), 64'd0);
      chk("R8", "open idle valid_o", 64'(v_b), 64'd0);
    end
  endtask

  function automatic logic [63:0] rand_addr();
    logic [63:0] b, s, off;
    int unsigned k;
    k = $urandom % 10;
    case (k)
      0: begin b = 64'h0;         s = 64'h1000;      end
      1: begin b = 64'h1_0000;    s = 64'h1_0000;    end
      2: begin b = 64'h8000_0000; s = 64'h4000_0000; end
      3: begin b = 64'h1000_0000; s = 64'h1000;      end
      4: begin b = 64'h2000_0000; s = 64'h100_0000;  end
      default: return {$urandom, $urandom};
    endcase
    case ($urandom % 5)
      0: off = 64'd0;
      1: off = s - 64'd1;
      2: off = s;
      3: off = -64'd1;
      default: off = 64'($urandom) % s;
    endcase
    return b + off;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000 && !done) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20190422));
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "reset valid_o", 64'(v_a), 64'd0);
    chk("R9", "reset exc_valid_o", 64'(ev_a), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 window edges, R3 misses just outside
    op(1, 1, 64'h0,          0, 0, 0);
    op(1, 1, 64'h0FFF,       0, 0, 0);
    op(1, 1, 64'h1000,       0, 0, 0);
    op(1, 1, 64'hFFFF,       0, 0, 0);
    op(1, 1, 64'h1_0000,     0, 0, 0);
    op(1, 1, 64'h1_FFFF,     0, 0, 0);
    op(1, 1, 64'h2_0000,     0, 0, 0);
    op(1, 1, 64'h7FFF_FFFF,  0, 0, 0);
    op(1, 1, 64'h8000_0000,  0, 0, 0);
    op(1, 1, 64'hBFFF_FFFF,  0, 0, 0);
    op(1, 1, 64'hC000_0000,  0, 0, 0);
    op(1, 1, 64'hFFFF_FFFF_8000_0000, 0, 0, 0);
    // R4 override, R5 pass-through of a page-fault-like record
    op(1, 1, 64'h5000_0000,  1, 64'd12, 64'hDEAD_BEEF);
    op(1, 1, 64'h8000_1000,  1, 64'd12, 64'hDEAD_BEEF);
    // R6 data access to a non-executable address, R7 side-effect windows
    op(1, 0, 64'h5000_0000,  0, 0, 0);
    op(1, 0, 64'h1000_0800,  0, 0, 0);
    op(1, 1, 64'h1000_0800,  0, 0, 0);
    op(1, 0, 64'h20FF_FFFF,  1, 64'd13, 64'h42);
    op(1, 0, 64'h2100_0000,  0, 0, 0);
    // R8 idle cycle
    op(0, 1, 64'h5000_0000,  0, 0, 0);

    for (int i = 0; i < 600; i++) begin
      logic p;
      p = ($urandom % 4) == 0;
      op(($urandom % 6) != 0, $urandom % 2, rand_addr(), p,
         {$urandom, $urandom}, {$urandom, $urandom});
    end

    // R9 reset taken after a fault clears the registered record
    op(1, 1, 64'h3000_0000, 0, 0, 0);
    @(negedge clk);
    rv = 1'b1; rf = 1'b1; pa = 64'h3000_0000;
    rst_n = 1'b0;
    #2;
    chk("R9", "mid reset valid_o", 64'(v_a), 64'd0);
    chk("R9", "mid reset exc_valid_o", 64'(ev_a), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    rv = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule